// File: doc/BRIEF.md
# Two-Bit Fixed-Equation Moore Sequencer

This block is a four-state synchronous machine held in two flip-flops, a high bit and a low bit. On every rising clock edge it loads a new state computed from the present state and a single-bit data input. The rule is fixed. The new high bit is the data input OR the present low bit. The new low bit is the data input AND the present high bit. The single-bit output is a Moore output: it is the AND of the two state bits, so it rises only while the machine sits in state 11.

A synchronous active-high reset returns the machine to state 00. The two state bits are brought out on a port so that the surrounding logic, or a bench, can observe where the machine is.

After reset the machine moves between states 00, 10 and 11 only. Under these equations no reachable state leads into 01, so state 01 is never entered.

Top module: `seq2_moore`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `state_o` is 2'b00 after that edge and `hit_o` is 0.
- R2: From state 2'b00 with `rst` low, `din`=0 keeps the state at 2'b00 and `din`=1 moves it to 2'b10 at the next rising edge.
- R3: From state 2'b10 with `rst` low, `din`=0 returns the state to 2'b00 and `din`=1 moves it to 2'b11 at the next rising edge.
- R4: From state 2'b11 with `rst` low, `din`=0 moves the state to 2'b10 and `din`=1 keeps it at 2'b11. `hit_o` is 1 throughout that cycle, whatever the value of `din`.
- R5: `hit_o` is 1 exactly when `state_o` is 2'b11. It depends only on the registered state, never on the present `din`.
- R6: After reset, `state_o` never takes the value 2'b01.
- R7: Starting from reset with `din` applied as 0,1,1,0,1 on successive edges, `state_o` reads 00,00,10,11,10,11 and `hit_o` reads 0,0,0,1,0,1. The first value in each list is the one present before the first of these edges.
- R8: Reset takes priority over `din`. With `rst`=1 and `din`=1 from state 2'b11, the state still becomes 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to state 2'b00 |
| din | input | 1 | Serial data input sampled at each rising edge |
| state_o | output | 2 | Registered state: bit 1 is the high bit, bit 0 is the low bit |
| hit_o | output | 1 | Moore output, 1 only in state 2'b11 |

## Verification
The assertions take for granted that `din` and `rst` are stable and known at every rising edge. They also take for granted that at least one reset edge comes before any transition check; that is why each property is disabled while `rst` is high. The stimulus meets both conditions. It drives `din` and `rst` only on the falling edge, and it starts with a reset cycle. Random values then run for thousands of cycles, with occasional resets mixed in, so that every reachable state sees both input values.

// File: rtl/seq2_pkg.sv
package seq2_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ODD  = 2'b01,
    ST_ARM  = 2'b10,
    ST_FIRE = 2'b11
  } seq2_state_e;

  localparam seq2_state_e RESET_STATE = ST_IDLE;
endpackage

// File: rtl/seq2_next.sv
module seq2_next
  import seq2_pkg::*;
(
  input  seq2_state_e cur,
  input  logic        din,
  output seq2_state_e nxt
);
  logic hi_n;
  logic lo_n;

  always_comb begin
    hi_n = din | cur[0];
    lo_n = din & cur[1];
    nxt  = seq2_state_e'({hi_n, lo_n});
  end
endmodule

// File: rtl/seq2_reg.sv
module seq2_reg
  import seq2_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  seq2_state_e d,
  output seq2_state_e q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_STATE;
    else     q <= d;
  end

  // R1 / R8: synchronous reset wins over any next-state value
  assert_reset_R1: assert property (@(posedge clk) rst |=> q == RESET_STATE)
    else $error("reset did not clear state");
endmodule

// File: rtl/seq2_decode.sv
module seq2_decode
  import seq2_pkg::*;
(
  input  seq2_state_e cur,
  output logic        hit
);
  always_comb hit = cur[1] & cur[0];
endmodule

// File: rtl/seq2_moore.sv
module seq2_moore
  import seq2_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  output logic [STATE_W-1:0] state_o,
  output logic               hit_o
);
  seq2_state_e cur;
  seq2_state_e nxt;

  seq2_next u_next (
    .cur (cur),
    .din (din),
    .nxt (nxt)
  );

  seq2_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (cur)
  );

  seq2_decode u_dec (
    .cur (cur),
    .hit (hit_o)
  );

  assign state_o = cur;

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1 && state_o == 2'b00) |=> state_o == ($past(din) ? 2'b10 : 2'b00))
    else $error("wrong move from 00");

  assert_arm_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1 && state_o == 2'b10) |=> state_o == ($past(din) ? 2'b11 : 2'b00))
    else $error("wrong move from 10");

  assert_fire_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_rst === 1'b1 && state_o == 2'b11) |=> state_o == ($past(din) ? 2'b11 : 2'b10))
    else $error("wrong move from 11");

  assert_hit_R5: assert property (@(posedge clk) disable iff (rst)
    seen_rst === 1'b1 |-> (hit_o == (state_o == 2'b11)))
    else $error("output does not track state 11");

  assert_no_odd_R6: assert property (@(posedge clk) disable iff (rst)
    seen_rst === 1'b1 |-> state_o != 2'b01)
    else $error("state 01 entered");
endmodule

// File: tb/tb_seq2_moore.sv
module tb_seq2_moore;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [1:0] state_o;
  logic       hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [1:0] model = 2'b00;

  always #10 clk = ~clk;

  seq2_moore dut (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .state_o (state_o),
    .hit_o   (hit_o)
  );

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic d, input logic r);
    if (r) return 2'b00;
    case (s)
      2'b00:   return d ? 2'b10 : 2'b00;
      2'b10:   return d ? 2'b11 : 2'b00;
      2'b11:   return d ? 2'b11 : 2'b10;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic ref_hit(input logic [1:0] s);
    return s == 2'b11;
  endfunction

  task automatic check(input string req, input logic [1:0] exp_s);
    checks++;
    if (state_o !== exp_s || hit_o !== ref_hit(exp_s)) begin
      fails++;
      $display("FAIL %s: state=%b hit=%b expected state=%b hit=%b",
               req, state_o, hit_o, exp_s, ref_hit(exp_s));
    end
  endtask

  // apply inputs on falling edge, check 1 ns after the next rising edge
  task automatic step(input logic d, input logic r, input string req);
    @(negedge clk);
    din = d;
    rst = r;
    @(posedge clk);
    #1;
    model = ref_next(model, d, r);
    check(req, model);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [1:0] exp_seq [6];
    logic [1:0] prev;
    void'($urandom(32'd20240611));
    exp_seq[0] = 2'b00; exp_seq[1] = 2'b00; exp_seq[2] = 2'b10;
    exp_seq[3] = 2'b11; exp_seq[4] = 2'b10; exp_seq[5] = 2'b11;

    // R1: reset state
    step(1'b0, 1'b1, "R1 reset");
    step(1'b1, 1'b1, "R1 reset with din=1");
    check("R7 initial", exp_seq[0]);

    // R7: reference sequence 0,1,1,0,1
    step(1'b0, 1'b0, "R7 step1");
    check("R7 seq1", exp_seq[1]);
    step(1'b1, 1'b0, "R7 step2");
    check("R7 seq2", exp_seq[2]);
    step(1'b1, 1'b0, "R7 step3");
    check("R7 seq3", exp_seq[3]);
    step(1'b0, 1'b0, "R7 step4");
    check("R7 seq4", exp_seq[4]);
    step(1'b1, 1'b0, "R7 step5");
    check("R7 seq5", exp_seq[5]);

    // R4: hold in 11, hit stays 1 with din=1
    step(1'b1, 1'b0, "R4 hold 11");
    // R8: reset from 11 with din=1
    step(1'b1, 1'b1, "R8 reset priority");
    // R2: 00 with din=0 stays
    step(1'b0, 1'b0, "R2 hold 00");
    step(1'b1, 1'b0, "R2 00 to 10");
    // R3: 10 with din=0 back to 00
    step(1'b0, 1'b0, "R3 10 to 00");
    step(1'b1, 1'b0, "R2 00 to 10 again");
    step(1'b1, 1'b0, "R3 10 to 11");
    // R4: 11 with din=0 to 10
    step(1'b0, 1'b0, "R4 11 to 10");

    // random run; R5 and R6 are covered by each check
    for (int i = 0; i < 4000; i++) begin
      logic d;
      logic r;
      d = 1'($urandom);
      r = ($urandom % 50) == 0;
      prev = model;
      if (r)                 step(d, r, "R8 random reset");
      else if (prev == 2'b00) step(d, r, "R2 random");
      else if (prev == 2'b10) step(d, r, "R3 random");
      else                    step(d, r, "R4 random");
      checks++;
      if (state_o === 2'b01) begin
        fails++;
        $display("FAIL R6: state=%b expected not 01", state_o);
      end
      checks++;
      if (hit_o !== (state_o == 2'b11)) begin
        fails++;
        $display("FAIL R5: hit=%b expected %b", hit_o, state_o == 2'b11);
      end
    end
    finish_run();
  end
endmodule